// File: doc/BRIEF.md
# Dual-Bus Data Address Pointer Unit

This block holds the pointer state used to address data operands in a two-bank data memory. Each cycle it issues one address or, for dual-operand instructions, two addresses: a 14-bit word address on an X bus and one on a Y bus, each with a valid flag. After the address is issued, the pointer that produced it can be advanced by a signed step, so walks through arrays, delay lines and circular buffers cost no extra cycles.

The request comes straight from instruction decode. It names a pointer, says whether the access is a read or a write, picks one of four index registers and one of two step slots, marks single or dual access, and enables or suppresses the post-modify. A 16-bit register port gives access to every register in the unit. Steps are normally 4-bit signed values. An external mode input widens them to 8 bits for pointers 0 and 3. A per-pointer flag turns on wrap-around arithmetic inside a buffer whose length is held in a configuration register.

Top module: `dptr_unit`

## Requirements
- R1: After reset (`rst_n` low) every register reads back as 0, and with no request both `x_valid` and `y_valid` are 0.
- R2: Register port map at `reg_addr`: 0–3 indirect pointers P0–P3; 4–5 direct pointers D0–D1; 6–9 index registers I0–I3; 10 extension E0; 11 extension E3; 12 wrap config W0; 13 wrap config W1; 14–15 read as 0. A write with `reg_we` high takes effect at the next rising edge. `reg_rdata` shows the addressed register combinationally.
- R3: Single access (`req_dual`=0): the selected register drives bits 13:0 of the address. Its bit 14 picks the bus: 0 selects X (`x_valid`=1) and 1 selects Y (`y_valid`=1). `req_direct`=1 selects D[`req_ptr[0]`], otherwise P[`req_ptr`]. Exactly one valid flag is high. Direct pointers are never post-modified.
- R4: Dual access: P0[13:0] is on `x_addr` and P3[13:0] is on `y_addr` in the same cycle, with both valid flags high whatever bit 14 of either pointer holds.
- R5: The 4-bit step field is taken from the selected index register. Reads use [3:0] for slot 0 and [7:4] for slot 1. Writes use [11:8] for slot 0 and [15:12] for slot 1. The field is a two's complement value from −8 to +7. In a dual access, P0 uses I[`req_sidx`] and P3 uses I[`req_ysidx`].
- R6: When `ext_step_en`=1 and the modified pointer is P0 or P3, the step is 8-bit signed. Its low nibble is the selected field. Its high nibble is the field at the same bit position in E0 (for P0) or E3 (for P3). Other pointers keep 4-bit steps.
- R7: With bit 15 of the pointer clear, the post-modify adds the sign-extended step to bits 14:0 modulo 2^15 and keeps bit 15. The issued address is the value before the modification.
- R8: With bit 15 set, the pointer wraps. W0 governs P0/P1 and W1 governs P2/P3. L = W[13:0]+1, and M = (smallest power of two ≥ L) − 1. The offset is ptr[13:0] & M, and the new offset is the offset plus the step, corrected once by ±L when it leaves 0..L−1. Bits 15:14 and the bits above M are kept.
- R9: With `req_update`=0 the request issues addresses and leaves every pointer unchanged.
- R10: If a register-port write and a post-modify target the same pointer in one cycle, the pointer takes the written value.
- R11: With `req_valid`=0 no address is valid and no pointer is modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_step_en | input | 1 | Widens steps to 8 bits for P0/P3 |
| req_valid | input | 1 | Address request present |
| req_dual | input | 1 | Dual access: P0 on X, P3 on Y |
| req_direct | input | 1 | Single access through a direct pointer |
| req_ptr | input | 2 | Pointer number for single access |
| req_write | input | 1 | Access is a write (selects step field) |
| req_slot | input | 1 | Step slot 0 or 1 |
| req_sidx | input | 2 | Index register for the single or X-side pointer |
| req_ysidx | input | 2 | Index register for P3 in a dual access |
| req_update | input | 1 | Enable post-modify |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 4 | Register port address |
| reg_wdata | input | 16 | Register port write data |
| reg_rdata | output | 16 | Register port read data |
| x_addr | output | 14 | X bus word address (0 when not valid) |
| x_valid | output | 1 | X address valid |
| y_addr | output | 14 | Y bus word address (0 when not valid) |
| y_valid | output | 1 | Y address valid |

## Verification
A wrong pointer value does not stay hidden. The next request that names that pointer shows it on `x_addr` or `y_addr` in the same cycle, and a corrupted bank bit shows up as the wrong valid flag. Step-selection or wrap errors therefore appear one request after the faulty update. The bench replays a walk in which each vector's addresses depend on every earlier update, and then reads the pointers back through the register port, so a single bad step is visible through all later accesses to that pointer.

// File: rtl/dptr_unit.sv
module dptr_unit #(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_step_en,
  input  logic          req_valid,
  input  logic          req_dual,
  input  logic          req_direct,
  input  logic [1:0]    req_ptr,
  input  logic          req_write,
  input  logic          req_slot,
  input  logic [1:0]    req_sidx,
  input  logic [1:0]    req_ysidx,
  input  logic          req_update,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] x_addr,
  output logic          x_valid,
  output logic [AW-1:0] y_addr,
  output logic          y_valid
);
  localparam int BANK = AW;
  localparam int MODF = AW + 1;

  logic [3:0][DW-1:0] rp, sd;
  logic [1:0][DW-1:0] rpd, mc;
  logic [DW-1:0] sde0, sde3;

  function automatic logic [7:0] pick_step(input logic [DW-1:0] s, input logic [DW-1:0] e,
                                           input logic wide, input logic wr, input logic slot);
    logic [3:0] lo, hi;
    case ({wr, slot})
      2'b00:   begin lo = s[3:0];   hi = e[3:0];   end
      2'b01:   begin lo = s[7:4];   hi = e[7:4];   end
      2'b10:   begin lo = s[11:8];  hi = e[11:8];  end
      default: begin lo = s[15:12]; hi = e[15:12]; end
    endcase
    return wide ? {hi, lo} : {{4{lo[3]}}, lo};
  endfunction

  function automatic logic [DW-1:0] advance(input logic [DW-1:0] p, input logic [7:0] st,
                                            input logic [DW-1:0] m);
    logic [AW-1:0] msk;
    logic [DW-1:0] sum, len;
    if (!p[MODF]) return {p[MODF], p[MODF-1:0] + {{(MODF-8){st[7]}}, st}};
    msk = m[AW-1:0];
    for (int i = AW-2; i >= 0; i--) msk[i] = msk[i] | msk[i+1];
    len = {2'b0, m[AW-1:0]} + 16'd1;
    sum = {2'b0, p[AW-1:0] & msk} + {{(DW-8){st[7]}}, st};
    if (sum[DW-1]) sum = sum + len;
    else if (sum > {2'b0, m[AW-1:0]}) sum = sum - len;
    return {p[MODF:BANK], (p[AW-1:0] & ~msk) | (sum[AW-1:0] & msk)};
  endfunction

  logic [DW-1:0] sel_val, nxt_a, nxt_b;
  logic [1:0]    pa;
  logic          mod_a, mod_b, wide_a;

  assign sel_val = req_direct ? rpd[req_ptr[0]] : rp[req_ptr];
  assign x_valid = req_valid & (req_dual | ~sel_val[BANK]);
  assign y_valid = req_valid & (req_dual |  sel_val[BANK]);
  assign x_addr  = !x_valid ? '0 : req_dual ? rp[0][AW-1:0] : sel_val[AW-1:0];
  assign y_addr  = !y_valid ? '0 : req_dual ? rp[3][AW-1:0] : sel_val[AW-1:0];

  assign pa     = req_dual ? 2'd0 : req_ptr;
  assign wide_a = ext_step_en & (pa == 2'd0 || pa == 2'd3);
  assign mod_a  = req_valid & req_update & (req_dual | ~req_direct);
  assign mod_b  = mod_a & req_dual;
  assign nxt_a  = advance(rp[pa],
                          pick_step(sd[req_sidx], (pa == 2'd0) ? sde0 : sde3, wide_a, req_write, req_slot),
                          mc[pa[1]]);
  assign nxt_b  = advance(rp[3], pick_step(sd[req_ysidx], sde3, ext_step_en, req_write, req_slot), mc[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; sd <= '0; rpd <= '0; mc <= '0; sde0 <= '0; sde3 <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (reg_we && reg_addr == 4'(i)) rp[i] <= reg_wdata;
        else if (mod_a && pa == 2'(i))   rp[i] <= nxt_a;
        else if (mod_b && i == 3)        rp[i] <= nxt_b;
        if (reg_we && reg_addr == 4'(i + 6)) sd[i] <= reg_wdata;
      end
      if (reg_we) begin
        case (reg_addr)
          4'd4:  rpd[0] <= reg_wdata;
          4'd5:  rpd[1] <= reg_wdata;
          4'd10: sde0   <= reg_wdata;
          4'd11: sde3   <= reg_wdata;
          4'd12: mc[0]  <= reg_wdata;
          4'd13: mc[1]  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0, 4'd1, 4'd2, 4'd3: reg_rdata = rp[reg_addr[1:0]];
      4'd4:  reg_rdata = rpd[0];
      4'd5:  reg_rdata = rpd[1];
      4'd6, 4'd7, 4'd8, 4'd9: reg_rdata = sd[reg_addr[1:0] - 2'd2];
      4'd10: reg_rdata = sde0;
      4'd11: reg_rdata = sde3;
      4'd12: reg_rdata = mc[0];
      4'd13: reg_rdata = mc[1];
      default: reg_rdata = '0;
    endcase
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !x_valid && !y_valid);
  // R3
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_dual |-> $countones({x_valid, y_valid}) == 1);
  // R4
  dual_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_dual |-> x_valid && y_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_a && !(reg_we && reg_addr < 4'd4) |=> $stable(rp));
  // R8
  wrap_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_a && rp[pa][MODF] |-> nxt_a[MODF:BANK] == rp[pa][MODF:BANK]);
endmodule

// File: tb/tb_dptr_unit.sv
module tb_dptr_unit;
  logic clk = 0, rst_n = 0;
  logic ext_step_en = 0, req_valid = 0, req_dual = 0, req_direct = 0;
  logic [1:0] req_ptr = 0, req_sidx = 0, req_ysidx = 0;
  logic req_write = 0, req_slot = 0, req_update = 0, reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [13:0] x_addr, y_addr;
  logic x_valid, y_valid;

  always #5 clk = ~clk;

  dptr_unit dut (.clk, .rst_n, .ext_step_en, .req_valid, .req_dual, .req_direct, .req_ptr,
                 .req_write, .req_slot, .req_sidx, .req_ysidx, .req_update, .reg_we, .reg_addr,
                 .reg_wdata, .reg_rdata, .x_addr, .x_valid, .y_addr, .y_valid);

  int checks = 0, fails = 0;
  int mreg [16];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mstep(int s, int e, bit wide, bit wr, bit slot);
    int sh = 4 * (int'(wr) * 2 + int'(slot));
    int lo = (s >> sh) & 15, hi = (e >> sh) & 15, v;
    if (wide) begin v = hi * 16 + lo; if (v >= 128) v -= 256; end
    else v = (lo >= 8) ? lo - 16 : lo;
    return v;
  endfunction

  function automatic int madv(int p, int st, int mc);
    int lm1, pw, a, off;
    if ((p & 32768) == 0) return (p & 32768) | (((p & 32767) + st) & 32767);
    lm1 = mc & 16383; pw = 1;
    while (pw <= lm1) pw *= 2;
    a = p & 16383;
    off = (a % pw) + st;
    if (off < 0) off += lm1 + 1;
    else if (off > lm1) off -= lm1 + 1;
    return (p & 49152) | (a - (a % pw)) | (off & (pw - 1));
  endfunction

  task automatic bus_wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
    if (a < 14) mreg[a] = d;
  endtask

  task automatic bus_rd(input string req, input int a, input int exp);
    @(negedge clk); reg_addr = 4'(a); #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  // {xv,yv,ext,upd,ysidx,sidx,slot,wr,ptr,direct,dual}
  localparam logic [13:0] VEC [16] = '{
    {2'b10,1'b0,1'b1,2'd0,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0},
    {2'b10,1'b0,1'b1,2'd0,2'd1,1'b1,1'b0,2'd0,1'b0,1'b0},
    {2'b01,1'b0,1'b1,2'd0,2'd2,1'b0,1'b1,2'd1,1'b0,1'b0},
    {2'b01,1'b0,1'b1,2'd0,2'd3,1'b1,1'b1,2'd1,1'b0,1'b0},
    {2'b10,1'b0,1'b1,2'd0,2'd2,1'b0,1'b0,2'd2,1'b0,1'b0},
    {2'b10,1'b0,1'b1,2'd0,2'd0,1'b1,1'b1,2'd2,1'b0,1'b0},
    {2'b01,1'b0,1'b1,2'd0,2'd3,1'b1,1'b0,2'd3,1'b0,1'b0},
    {2'b10,1'b0,1'b1,2'd0,2'd0,1'b0,1'b0,2'd0,1'b1,1'b0},
    {2'b01,1'b0,1'b1,2'd0,2'd1,1'b0,1'b0,2'd1,1'b1,1'b0},
    {2'b11,1'b0,1'b1,2'd3,2'd0,1'b0,1'b0,2'd0,1'b0,1'b1},
    {2'b11,1'b1,1'b1,2'd2,2'd1,1'b1,1'b1,2'd0,1'b0,1'b1},
    {2'b10,1'b1,1'b1,2'd0,2'd2,1'b1,1'b0,2'd0,1'b0,1'b0},
    {2'b01,1'b1,1'b1,2'd0,2'd1,1'b0,1'b1,2'd3,1'b0,1'b0},
    {2'b01,1'b1,1'b1,2'd0,2'd0,1'b0,1'b0,2'd1,1'b0,1'b0},
    {2'b10,1'b1,1'b0,2'd0,2'd3,1'b0,1'b0,2'd2,1'b0,1'b0},
    {2'b11,1'b1,1'b1,2'd0,2'd3,1'b0,1'b0,2'd0,1'b0,1'b1}
  };

  bit done = 0;

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin checks++; fails++; $display("FAIL watchdog expired"); finish_run(); end
  end

  initial begin
    foreach (mreg[i]) mreg[i] = 0;
    #22 rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 14; a++) bus_rd("R1 reset reg", a, 0);
    chk("R1 idle valid", {x_valid, y_valid}, 0);

    // R2: register map
    bus_wr(0, 16'h0800); bus_wr(1, 16'hC020); bus_wr(2, 16'h8105); bus_wr(3, 16'hC203);
    bus_wr(4, 16'h0300); bus_wr(5, 16'h4400);
    bus_wr(6, 16'h7F81); bus_wr(7, 16'h2E93); bus_wr(8, 16'h5A4C); bus_wr(9, 16'h16B7);
    bus_wr(10, 16'h3C8F); bus_wr(11, 16'hA15E); bus_wr(12, 16'h0009); bus_wr(13, 16'h0006);
    bus_wr(14, 16'hFFFF);
    for (int a = 0; a < 16; a++) bus_rd("R2 map", a, (a < 14) ? mreg[a] : 0);

    // R3 R4 R5 R6 R7 R8: vector walk against the model
    foreach (VEC[i]) begin
      logic [13:0] v = VEC[i];
      int p, xe, ye, nb, sel, st;
      @(negedge clk);
      req_valid = 1; req_dual = v[0]; req_direct = v[1]; req_ptr = v[3:2];
      req_write = v[4]; req_slot = v[5]; req_sidx = v[7:6]; req_ysidx = v[9:8];
      req_update = v[10]; ext_step_en = v[11];
      #1;
      chk("R3 R4 valid flags", {x_valid, y_valid}, v[13:12]);
      sel = v[1] ? mreg[4 + v[2]] : mreg[v[3:2]];
      xe = v[0] ? (mreg[0] & 16383) : sel & 16383;
      ye = v[0] ? (mreg[3] & 16383) : sel & 16383;
      if (v[13]) chk("R3 R4 x_addr", x_addr, xe);
      if (v[12]) chk("R3 R4 y_addr", y_addr, ye);
      if (v[10] && (v[0] || !v[1])) begin
        p = v[0] ? 0 : v[3:2];
        st = mstep(mreg[6 + v[7:6]], (p == 0) ? mreg[10] : mreg[11],
                   v[11] && (p == 0 || p == 3), v[4], v[5]);
        nb = madv(mreg[p], st, mreg[12 + p / 2]);
        if (v[0]) begin
          st = mstep(mreg[6 + v[9:8]], mreg[11], v[11], v[4], v[5]);
          mreg[3] = madv(mreg[3], st, mreg[13]);
        end
        mreg[p] = nb;
      end
    end
    @(negedge clk); req_valid = 0; ext_step_en = 0;
    for (int a = 0; a < 6; a++) bus_rd("R5 R6 R7 R8 pointer after walk", a, mreg[a]);

    // R11: idle issues nothing and holds pointers
    @(negedge clk); req_valid = 0; req_update = 1; req_ptr = 2; req_direct = 0; req_dual = 0; #1;
    chk("R11 idle flags", {x_valid, y_valid}, 0);
    bus_rd("R11 pointer held", 2, mreg[2]);

    // R9: update disabled
    @(negedge clk); req_valid = 1; req_update = 0; req_ptr = 1; req_sidx = 0; #1;
    chk("R9 addr issued", y_addr, mreg[1] & 16383);
    @(negedge clk); req_valid = 0;
    bus_rd("R9 pointer unchanged", 1, mreg[1]);

    // R7: linear carry into bit 14, bit 15 kept
    bus_wr(0, 16'h3FFF); bus_wr(6, 16'h0007);
    @(negedge clk); req_valid = 1; req_update = 1; req_dual = 0; req_direct = 0; req_ptr = 0;
    req_write = 0; req_slot = 0; req_sidx = 0; #1;
    chk("R7 pre-modify addr", x_addr, 14'h3FFF);
    @(negedge clk); req_valid = 0;
    bus_rd("R7 carry into bank bit", 0, 16'h4006);

    // R8: wrap below base for P2 via W1 (L=7)
    bus_wr(2, 16'h8101); bus_wr(8, 16'h000D);
    @(negedge clk); req_valid = 1; req_ptr = 2; req_sidx = 2; #1;
    @(negedge clk); req_valid = 0;
    bus_rd("R8 wrap low", 2, 16'h8105);

    // R10: bus write beats post-modify
    @(negedge clk); req_valid = 1; req_update = 1; req_ptr = 2; req_sidx = 2;
    reg_we = 1; reg_addr = 4'd2; reg_wdata = 16'h1234;
    @(negedge clk); req_valid = 0; reg_we = 0;
    bus_rd("R10 write wins", 2, 16'h1234);

    done = 1;
    finish_run();
  end
endmodule